// File: doc/BRIEF.md
# Bursting DMA Slave Local Arbiter

This block is the local arbitration controller for an add-in card that services a single, already selected DMA request over a shared, preemptive arbitration bus. When the card's device request becomes active, the block asks for the bus by driving a preempt line. During the arbitration phase it enables the card's arbitration vector onto the bus. Once the card wins, it raises BURST and an acknowledge while the system DMA controller moves data.

The transfer ends when the slave drops its request. The block then leaves BURST through one intermediate state, returns to idle, and keeps the next request off the bus for a minimum gap. A cycle counter limits how long a burst may continue once another agent is preempting. All inputs are asynchronous to the block clock and pass through a synchronizer first. Time limits are given in nanoseconds and converted to cycles from a clock-period parameter.

Top module: `dma_burst_arbiter`

## Requirements
- R1: After `rst_n` is released, `burst_o`, `preempt_o`, `ack_o` and `vec_en_o` are all low.
- R2: In idle, with the gap elapsed, an active `dev_req` moves the block to the request state, where `preempt_o` is high and `vec_en_o`, `burst_o` and `ack_o` are low.
- R3: While requesting, a high `arb_phase` moves the block to arbitration, where both `preempt_o` and `vec_en_o` are high.
- R4: A high `bus_won` during arbitration, with the request still active, starts the burst. `burst_o` and `ack_o` go high, and `preempt_o` and `vec_en_o` go low.
- R5: If `arb_phase` falls during arbitration without `bus_won`, the block returns to the request state (`preempt_o` high, `vec_en_o` low) and competes again at the next arbitration phase.
- R6: When `dev_req` goes low during a burst, `burst_o` and `ack_o` fall and the block passes through one intermediate state with all outputs low before it reaches idle.
- R7: After every burst ends, `preempt_o` stays low for at least GAP_NS rounded up to whole clock cycles, measured from the cycle in which `burst_o` falls, even if `dev_req` stays active.
- R8: If `preempt_in` stays high for PREEMPT_LIMIT_NS (in whole cycles) during a burst, `burst_o` is released. A shorter `preempt_in` pulse leaves the burst running.
- R9: A high `chan_rst` returns the block to idle on the next clock after synchronization. It holds `burst_o`, `preempt_o`, `ack_o` and `vec_en_o` low while it stays high, and it clears the gap.
- R10: If `dev_req` falls in the request state before any win, the block withdraws to idle and `preempt_o` falls, with no burst and no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_req | input | 1 | Selected device DMA request (asynchronous) |
| arb_phase | input | 1 | High while the bus is in its arbitration phase (asynchronous) |
| bus_won | input | 1 | High when this card's vector has won arbitration (asynchronous) |
| preempt_in | input | 1 | Preempt driven by another agent (asynchronous) |
| chan_rst | input | 1 | Channel reset, synchronous in effect (asynchronous pin) |
| burst_o | output | 1 | Burst held for the duration of the transfer |
| preempt_o | output | 1 | Preempt drive used to request the bus |
| ack_o | output | 1 | Acknowledge that the request is being served |
| vec_en_o | output | 1 | Enable placing the card's arbitration vector on the bus |

## Verification
The main sequence is run with four request patterns:
- A request withdrawn before arbitration, which separates the withdraw path from a burst.
- A clean win followed by the request dropping, which checks the full idle–request–arbitrate–burst–end order.
- A lost arbitration followed by a win, which shows the return to requesting rather than to idle.
- A burst held past the preempt limit while the request stays high, which exercises the forced release and then the minimum gap before the automatic re-request.

A preempt pulse shorter than the limit and a channel reset in mid-burst show that the timeout counter does not trip early and that the reset overrides an active request.

// File: rtl/dba_pkg.sv
package dba_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ARB  = 3'd2,
    ST_XFR  = 3'd3,
    ST_END  = 3'd4
  } arb_state_e;

  // Index of each asynchronous input inside the synchronizer vector
  localparam int IDX_REQ  = 0;
  localparam int IDX_ARB  = 1;
  localparam int IDX_WON  = 2;
  localparam int IDX_PRE  = 3;
  localparam int IDX_CRST = 4;
  localparam int N_ASYNC  = 5;

endpackage

// File: rtl/dba_sync.sv
module dba_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
      end
      assign sync_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dba_gap_timer.sv
module dba_gap_timer #(
  parameter int GAP_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic done
);

  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || load || (cnt_q != '0);
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = LOAD_VAL;
    else           cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dba_preempt_timer.sv
module dba_preempt_timer #(
  parameter int LIMIT_CYC = 780000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);

  localparam int CW = (LIMIT_CYC > 1) ? $clog2(LIMIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !run || (cnt_q != LAST);
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit = run && (cnt_q == LAST);

endmodule

// File: rtl/dba_fsm.sv
module dba_fsm
  import dba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic arb_s,
  input  logic won_s,
  input  logic crst_s,
  input  logic gap_done,
  input  logic tmo_hit,
  output logic in_xfr,
  output logic in_end,
  output logic burst_o,
  output logic preempt_o,
  output logic ack_o,
  output logic vec_en_o
);

  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (crst_s) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_s && gap_done) state_d = ST_REQ;
        ST_REQ: begin
          if (!req_s)     state_d = ST_IDLE;
          else if (arb_s) state_d = ST_ARB;
        end
        ST_ARB: begin
          if (!req_s)      state_d = ST_IDLE;
          else if (won_s)  state_d = ST_XFR;
          else if (!arb_s) state_d = ST_REQ;
        end
        ST_XFR:  if (!req_s || tmo_hit) state_d = ST_END;
        ST_END:  state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    burst_o   = 1'b0;
    preempt_o = 1'b0;
    ack_o     = 1'b0;
    vec_en_o  = 1'b0;
    unique case (state_q)
      ST_REQ: preempt_o = 1'b1;
      ST_ARB: begin
        preempt_o = 1'b1;
        vec_en_o  = 1'b1;
      end
      ST_XFR: begin
        burst_o = 1'b1;
        ack_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign in_xfr = (state_q == ST_XFR);
  assign in_end = (state_q == ST_END);

  // R2
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && gap_done && req_s && !crst_s) |=> preempt_o);

  // R4
  win_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARB && req_s && won_s && !crst_s) |=> (burst_o && ack_o && !vec_en_o));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_o && !req_s && !crst_s) |=> (!burst_o && state_q == ST_END));

  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_END && !crst_s) |=> (!preempt_o && !gap_done));

  // R8
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFR && tmo_hit && !crst_s) |=> !burst_o);

  // R9
  crst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crst_s |=> (!burst_o && !preempt_o && !vec_en_o && !ack_o));

endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
  import dba_pkg::*;
#(
  parameter int CLK_PERIOD_NS    = 10,
  parameter int GAP_NS           = 100,
  parameter int PREEMPT_LIMIT_NS = 7_800_000,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req,
  input  logic arb_phase,
  input  logic bus_won,
  input  logic preempt_in,
  input  logic chan_rst,
  output logic burst_o,
  output logic preempt_o,
  output logic ack_o,
  output logic vec_en_o
);

  localparam int GAP_CYC_RAW = (GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int GAP_CYC     = (GAP_CYC_RAW < 1) ? 1 : GAP_CYC_RAW;
  localparam int TMO_CYC_RAW = PREEMPT_LIMIT_NS / CLK_PERIOD_NS;
  localparam int TMO_CYC     = (TMO_CYC_RAW < 1) ? 1 : TMO_CYC_RAW;

  logic [N_ASYNC-1:0] async_v, sync_v;
  logic gap_done, tmo_hit, in_xfr, in_end;

  always_comb begin
    async_v           = '0;
    async_v[IDX_REQ]  = dev_req;
    async_v[IDX_ARB]  = arb_phase;
    async_v[IDX_WON]  = bus_won;
    async_v[IDX_PRE]  = preempt_in;
    async_v[IDX_CRST] = chan_rst;
  end

  dba_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_v),
    .sync_o  (sync_v)
  );

  dba_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_v[IDX_CRST]),
    .load  (in_end),
    .done  (gap_done)
  );

  dba_preempt_timer #(.LIMIT_CYC(TMO_CYC)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_xfr && sync_v[IDX_PRE]),
    .hit   (tmo_hit)
  );

  dba_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (sync_v[IDX_REQ]),
    .arb_s     (sync_v[IDX_ARB]),
    .won_s     (sync_v[IDX_WON]),
    .crst_s    (sync_v[IDX_CRST]),
    .gap_done  (gap_done),
    .tmo_hit   (tmo_hit),
    .in_xfr    (in_xfr),
    .in_end    (in_end),
    .burst_o   (burst_o),
    .preempt_o (preempt_o),
    .ack_o     (ack_o),
    .vec_en_o  (vec_en_o)
  );

endmodule

// File: tb/sim_dma_burst_arbiter.sv
module sim_dma_burst_arbiter;

  localparam int CLK_NS  = 10;
  localparam int GAP_CYC = 10;
  localparam int TMO_CYC = 50;

  logic clk, rst_n;
  logic dev_req, arb_phase, bus_won, preempt_in, chan_rst;
  logic burst_o, preempt_o, ack_o, vec_en_o;

  int n_chk, n_fail, cyc;
  int fall_cyc, rise_cyc, pre_cyc;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  dma_burst_arbiter #(
    .CLK_PERIOD_NS    (CLK_NS),
    .GAP_NS           (GAP_CYC * CLK_NS),
    .PREEMPT_LIMIT_NS (TMO_CYC * CLK_NS)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_req    (dev_req),
    .arb_phase  (arb_phase),
    .bus_won    (bus_won),
    .preempt_in (preempt_in),
    .chan_rst   (chan_rst),
    .burst_o    (burst_o),
    .preempt_o  (preempt_o),
    .ack_o      (ack_o),
    .vec_en_o   (vec_en_o)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  // Output vector: {burst, preempt, ack, vec_en}
  task automatic check(input string tag, input int got, input int expv);
    n_chk++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic check_range(input string tag, input int got, input int lo, input int hi);
    n_chk++;
    if (got < lo || got > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic expect_out(input logic [3:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares every change of the output vector with the scoreboard
  initial begin
    logic [3:0] prev, cur, e;
    string t;
    prev = 4'b0000;
    cyc  = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (rst_n) begin
        cur = {burst_o, preempt_o, ack_o, vec_en_o};
        if (cur !== prev) begin
          if (prev[3] && !cur[3]) fall_cyc = cyc;
          if (!prev[2] && cur[2]) rise_cyc = cyc;
          if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL unexpected change: actual %b expected none", cur);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (cur !== e) begin
              n_fail++;
              $display("FAIL %s: actual %b expected %b", t, cur, e);
            end
          end
          prev = cur;
        end
      end
    end
  end

  task automatic run_all();
    rst_n = 1'b0; dev_req = 0; arb_phase = 0; bus_won = 0; preempt_in = 0; chan_rst = 0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1 reset state
    check("R1 reset outputs", {burst_o, preempt_o, ack_o, vec_en_o}, 0);

    // R10 withdraw before arbitration
    expect_out(4'b0100, "R2 request");
    expect_out(4'b0000, "R10 withdraw");
    dev_req = 1; wait_cyc(6);
    dev_req = 0; wait_cyc(6);

    // R3 R4 R6 clean burst, with a short preempt pulse (R8)
    expect_out(4'b0100, "R2 request");
    expect_out(4'b0101, "R3 arbitrate");
    expect_out(4'b1010, "R4 burst");
    expect_out(4'b0000, "R6 end");
    dev_req = 1; wait_cyc(5);
    arb_phase = 1; wait_cyc(5);
    bus_won = 1; wait_cyc(4);
    arb_phase = 0; bus_won = 0; wait_cyc(2);
    preempt_in = 1; wait_cyc(TMO_CYC - 20);
    preempt_in = 0; wait_cyc(5);
    check("R8 short preempt keeps burst", burst_o, 1);
    dev_req = 0; wait_cyc(6);
    check("R6 idle after end", {burst_o, preempt_o, ack_o, vec_en_o}, 0);
    wait_cyc(GAP_CYC + 5);

    // R5 lost arbitration then win
    expect_out(4'b0100, "R2 request");
    expect_out(4'b0101, "R3 arbitrate");
    expect_out(4'b0100, "R5 lost");
    expect_out(4'b0101, "R5 retry");
    expect_out(4'b1010, "R4 burst");
    expect_out(4'b0000, "R6 end");
    dev_req = 1; wait_cyc(5);
    arb_phase = 1; wait_cyc(5);
    arb_phase = 0; wait_cyc(5);
    check("R5 requesting again", {burst_o, preempt_o, ack_o, vec_en_o}, 4);
    arb_phase = 1; wait_cyc(5);
    bus_won = 1; wait_cyc(5);
    arb_phase = 0; bus_won = 0; wait_cyc(3);
    dev_req = 0; wait_cyc(GAP_CYC + 5);

    // R8 timeout release, R7 gap before automatic re-request
    expect_out(4'b0100, "R2 request");
    expect_out(4'b0101, "R3 arbitrate");
    expect_out(4'b1010, "R4 burst");
    expect_out(4'b0000, "R8 timeout release");
    expect_out(4'b0100, "R7 re-request");
    expect_out(4'b0000, "R10 withdraw");
    dev_req = 1; wait_cyc(5);
    arb_phase = 1; wait_cyc(5);
    bus_won = 1; wait_cyc(5);
    arb_phase = 0; bus_won = 0; wait_cyc(2);
    preempt_in = 1; pre_cyc = cyc;
    wait_cyc(TMO_CYC + 15);
    check("R8 burst released", burst_o, 0);
    check_range("R8 release latency", fall_cyc - pre_cyc, TMO_CYC, TMO_CYC + 6);
    wait_cyc(GAP_CYC + 10);
    check("R7 re-request after gap", preempt_o, 1);
    check_range("R7 gap length", rise_cyc - fall_cyc, GAP_CYC, GAP_CYC + 4);
    preempt_in = 0; dev_req = 0; wait_cyc(6);
    wait_cyc(GAP_CYC + 5);

    // R9 channel reset during a burst
    expect_out(4'b0100, "R2 request");
    expect_out(4'b0101, "R3 arbitrate");
    expect_out(4'b1010, "R4 burst");
    expect_out(4'b0000, "R9 channel reset");
    dev_req = 1; wait_cyc(5);
    arb_phase = 1; wait_cyc(5);
    bus_won = 1; wait_cyc(5);
    arb_phase = 0; bus_won = 0; wait_cyc(3);
    chan_rst = 1; wait_cyc(6);
    check("R9 outputs held low", {burst_o, preempt_o, ack_o, vec_en_o}, 0);
    dev_req = 0; chan_rst = 0; wait_cyc(8);
    check("R6 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; fall_cyc = 0; rise_cyc = 0; pre_cyc = 0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule